// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block takes a power-save command from the processor and moves the chip into one of two low-power modes. The command's mode parameter picks the mode. In sleep, the processor and peripheral clock enables drop and the on-chip oscillator is switched off. In idle, only the processor clock is gated, so the peripherals keep running. The block drives the clock-enable outputs that a clock tree uses to gate its branches. It also drives the enables for the low-power RC oscillator, the fail-safe clock monitor and brown-out protection.

A low-power mode ends when one of the following arrives, and the block then returns to run on the next clock edge:

- an interrupt that is requested, individually enabled and of a priority strictly above the current processor priority;
- any power-on, brown-out or external reset source;
- a watchdog time-out.

While running, the block tracks the active clock source. It takes the current-oscillator code when clock switching is enabled and the fixed configured source otherwise. It freezes that code on entry to a low-power mode, so the same source is presented for restart on wake. The low-power RC oscillator stays enabled through sleep only when the watchdog is enabled.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block leaves that edge in run mode (`pwr_mode` = 0), all clock enables high and `clk_src` = 0.
- R2: A `cmd_valid` in run mode with `cmd_sleep` = 1 gives sleep (`pwr_mode` = 2) from the next cycle. In sleep, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R3: A `cmd_valid` in run mode with `cmd_sleep` = 0 gives idle (`pwr_mode` = 1) from the next cycle. In idle, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R4: `fscm_en` equals `fscm_cfg` in run and idle, and is 0 in sleep.
- R5: `lprc_en` is 0 only in sleep with `wdt_en` = 0, and is 1 otherwise.
- R6: `bor_en` follows `bor_cfg` in every mode, sleep included.
- R7: In idle or sleep, an interrupt line i with `irq_req[i]` = 1, `irq_en[i]` = 1 and priority `irq_prio[3*i+2:3*i]` strictly greater than `cpu_prio` returns the block to run on the next cycle. Equal or lower priority, or a disabled line, does not wake the block.
- R8: In idle or sleep, any of `rst_por`, `rst_bor`, `rst_ext` or `wdt_wake` returns the block to run on the next cycle.
- R9: In run, `clk_src` loads `cur_osc` when `clk_sw_en` = 1 and `dflt_osc` otherwise, with one cycle of latency. In idle or sleep, and in the first run cycle after wake, `clk_src` holds the code captured when the mode was entered.
- R10: `cmd_valid` is ignored while in idle or sleep. Without a wake condition, the mode stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Power-save command strobe |
| cmd_sleep | input | 1 | Command parameter: 1 sleep, 0 idle |
| irq_req | input | 8 | Interrupt requests |
| irq_en | input | 8 | Per-line interrupt enables |
| irq_prio | input | 24 | Packed 3-bit priority per line, line i at bits 3i+2:3i |
| cpu_prio | input | 3 | Current processor priority |
| rst_por | input | 1 | Power-on reset source |
| rst_bor | input | 1 | Brown-out reset source |
| rst_ext | input | 1 | External reset pin source |
| wdt_wake | input | 1 | Watchdog time-out wake request |
| wdt_en | input | 1 | Watchdog enabled |
| clk_sw_en | input | 1 | Clock switching enabled |
| cur_osc | input | 3 | Current-oscillator code |
| dflt_osc | input | 3 | Configured single clock source |
| fscm_cfg | input | 1 | Fail-safe monitor configured on |
| bor_cfg | input | 1 | Brown-out protection configured on |
| pwr_mode | output | 2 | Mode: 0 run, 1 idle, 2 sleep |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | On-chip oscillator enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| bor_en | output | 1 | Brown-out protection enable |
| clk_src | output | 3 | Saved clock-source code for restart |

## Verification
The embedded assertions check several properties on every cycle:

- an accepted command reaches its target mode one edge later;
- a wake condition in a low-power mode brings the block back to run;
- without a wake, the low-power mode holds;
- the saved clock source cannot change while the block is in idle or sleep;
- the RC oscillator cannot drop while the watchdog is enabled;
- no line wakes the block unless it is both requested and enabled.

The strict priority comparison at the equal-priority boundary, the mapping from source code to clock selection and the restoration of the captured code on wake are shown only by the bench scenarios. The bench compares those scenarios against its own model of the mode, the output decode and the saved code.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int NUM_IRQ = 8;
    localparam int PRIO_W  = 3;
    localparam int CSRC_W  = 3;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2
    } pm_mode_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic lprc;
        logic fscm;
        logic bor;
    } clk_ctl_t;

    // Output decode for a given mode and configuration
    function automatic clk_ctl_t decode_ctl(pm_mode_e m, logic wdt_on,
                                            logic fscm_on, logic bor_on);
        clk_ctl_t c;
        c.cpu  = (m == PM_RUN);
        c.per  = (m != PM_SLEEP);
        c.osc  = (m != PM_SLEEP);
        c.lprc = (m != PM_SLEEP) | wdt_on;
        c.fscm = (m != PM_SLEEP) & fscm_on;
        c.bor  = bor_on;
        return c;
    endfunction

    function automatic pm_mode_e cmd_target(logic sleep_sel);
        return sleep_sel ? PM_SLEEP : PM_IDLE;
    endfunction

endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual
    import pmc_pkg::*;
#(
    parameter int N  = NUM_IRQ,
    parameter int PW = PRIO_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    irq_req,
    input  logic [N-1:0]    irq_en,
    input  logic [N*PW-1:0] irq_prio,
    input  logic [PW-1:0]   cpu_prio,
    input  logic            rst_por,
    input  logic            rst_bor,
    input  logic            rst_ext,
    input  logic            wdt_wake,
    output logic            irq_wake,
    output logic            wake
);

    logic [N-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_line
            logic [PW-1:0] lvl;
            assign lvl     = irq_prio[gi*PW +: PW];
            assign hit[gi] = irq_req[gi] & irq_en[gi] & (lvl > cpu_prio);
        end
    endgenerate

    assign irq_wake = |hit;
    assign wake     = irq_wake | rst_por | rst_bor | rst_ext | wdt_wake;

    // R7
    no_unarmed_wake_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & irq_en) == '0) |-> !irq_wake);

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  logic     cmd_sleep,
    input  logic     wake,
    output pm_mode_e mode_q
);

    pm_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            PM_RUN:   if (cmd_valid) mode_d = cmd_target(cmd_sleep);
            PM_IDLE,
            PM_SLEEP: if (wake) mode_d = PM_RUN;
            default:  mode_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_RUN;
        else     mode_q <= mode_d;
    end

    // R2
    enter_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_RUN && cmd_valid && cmd_sleep) |=> (mode_q == PM_SLEEP));

    // R3
    enter_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_RUN && cmd_valid && !cmd_sleep) |=> (mode_q == PM_IDLE));

    // R8
    wake_to_run_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != PM_RUN && wake) |=> (mode_q == PM_RUN));

    // R10
    lp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != PM_RUN && !wake) |=> $stable(mode_q));

endmodule

// File: rtl/pmc_clk_ctrl.sv
module pmc_clk_ctrl
    import pmc_pkg::*;
#(
    parameter int CW = CSRC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  pm_mode_e      mode,
    input  logic          clk_sw_en,
    input  logic [CW-1:0] cur_osc,
    input  logic [CW-1:0] dflt_osc,
    input  logic          wdt_en,
    input  logic          fscm_cfg,
    input  logic          bor_cfg,
    output clk_ctl_t      ctl,
    output logic [CW-1:0] clk_src_q
);

    logic [CW-1:0] live_src;

    assign live_src = clk_sw_en ? cur_osc : dflt_osc;
    assign ctl      = decode_ctl(mode, wdt_en, fscm_cfg, bor_cfg);

    always_ff @(posedge clk) begin
        if (rst)                clk_src_q <= '0;
        else if (mode == PM_RUN) clk_src_q <= live_src;
    end

    // R9
    src_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != PM_RUN) |=> $stable(clk_src_q));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic                      cmd_sleep,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]         cpu_prio,
    input  logic                      rst_por,
    input  logic                      rst_bor,
    input  logic                      rst_ext,
    input  logic                      wdt_wake,
    input  logic                      wdt_en,
    input  logic                      clk_sw_en,
    input  logic [CSRC_W-1:0]         cur_osc,
    input  logic [CSRC_W-1:0]         dflt_osc,
    input  logic                      fscm_cfg,
    input  logic                      bor_cfg,
    output logic [1:0]                pwr_mode,
    output logic                      cpu_clk_en,
    output logic                      per_clk_en,
    output logic                      osc_en,
    output logic                      lprc_en,
    output logic                      fscm_en,
    output logic                      bor_en,
    output logic [CSRC_W-1:0]         clk_src
);

    logic     irq_wake;
    logic     wake;
    pm_mode_e mode_q;
    clk_ctl_t ctl;

    pmc_wake_qual #(.N(NUM_IRQ), .PW(PRIO_W)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .irq_prio (irq_prio),
        .cpu_prio (cpu_prio),
        .rst_por  (rst_por),
        .rst_bor  (rst_bor),
        .rst_ext  (rst_ext),
        .wdt_wake (wdt_wake),
        .irq_wake (irq_wake),
        .wake     (wake)
    );

    pmc_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_sleep (cmd_sleep),
        .wake      (wake),
        .mode_q    (mode_q)
    );

    pmc_clk_ctrl #(.CW(CSRC_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .clk_sw_en (clk_sw_en),
        .cur_osc   (cur_osc),
        .dflt_osc  (dflt_osc),
        .wdt_en    (wdt_en),
        .fscm_cfg  (fscm_cfg),
        .bor_cfg   (bor_cfg),
        .ctl       (ctl),
        .clk_src_q (clk_src)
    );

    assign pwr_mode   = mode_q;
    assign cpu_clk_en = ctl.cpu;
    assign per_clk_en = ctl.per;
    assign osc_en     = ctl.osc;
    assign lprc_en    = ctl.lprc;
    assign fscm_en    = ctl.fscm;
    assign bor_en     = ctl.bor;

    // R5
    lprc_with_wdt_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_en |-> lprc_en);

    // R2
    sleep_gates_all_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd2) |-> !(cpu_clk_en | per_clk_en | osc_en));

    // R6
    bor_kept_chk: assert property (@(posedge clk) disable iff (rst)
        bor_en == bor_cfg);

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_sleep;
    logic [7:0]  irq_req, irq_en;
    logic [23:0] irq_prio;
    logic [2:0]  cpu_prio;
    logic        rst_por, rst_bor, rst_ext, wdt_wake, wdt_en;
    logic        clk_sw_en;
    logic [2:0]  cur_osc, dflt_osc;
    logic        fscm_cfg, bor_cfg;
    logic [1:0]  pwr_mode;
    logic        cpu_clk_en, per_clk_en, osc_en, lprc_en, fscm_en, bor_en;
    logic [2:0]  clk_src;

    int checks = 0;
    int failures = 0;
    int m_mode = 0;
    logic [2:0] m_src = 3'd0;

    always #4 clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sleep(cmd_sleep),
        .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
        .cpu_prio(cpu_prio), .rst_por(rst_por), .rst_bor(rst_bor),
        .rst_ext(rst_ext), .wdt_wake(wdt_wake), .wdt_en(wdt_en),
        .clk_sw_en(clk_sw_en), .cur_osc(cur_osc), .dflt_osc(dflt_osc),
        .fscm_cfg(fscm_cfg), .bor_cfg(bor_cfg), .pwr_mode(pwr_mode),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .lprc_en(lprc_en), .fscm_en(fscm_en), .bor_en(bor_en),
        .clk_src(clk_src)
    );

    function automatic bit f_irq_wake(logic [7:0] rq, logic [7:0] en,
                                      logic [23:0] pr, logic [2:0] cp);
        bit w = 0;
        for (int i = 0; i < 8; i++)
            if (rq[i] && en[i] && (pr[3*i +: 3] > cp)) w = 1;
        return w;
    endfunction

    function automatic bit f_wake();
        return f_irq_wake(irq_req, irq_en, irq_prio, cpu_prio) |
               rst_por | rst_bor | rst_ext | wdt_wake;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare every output against the model for the present state and inputs
    task automatic check_all();
        chk("R2/R3/R10 pwr_mode", pwr_mode, m_mode);
        chk("R2/R3 cpu_clk_en", cpu_clk_en, m_mode == 0);
        chk("R2/R3 per_clk_en", per_clk_en, m_mode != 2);
        chk("R2/R3 osc_en", osc_en, m_mode != 2);
        chk("R5 lprc_en", lprc_en, (m_mode != 2) || wdt_en);
        chk("R4 fscm_en", fscm_en, (m_mode != 2) && fscm_cfg);
        chk("R6 bor_en", bor_en, bor_cfg);
        chk("R9 clk_src", clk_src, m_src);
    endtask

    task automatic model_step();
        if (rst) begin
            m_mode = 0;
            m_src  = 3'd0;
        end else if (m_mode == 0) begin
            m_src = clk_sw_en ? cur_osc : dflt_osc;
            if (cmd_valid) m_mode = cmd_sleep ? 2 : 1;
        end else if (f_wake()) begin
            m_mode = 0;
        end
    endtask

    task automatic quiet();
        cmd_valid = 0; cmd_sleep = 0; irq_req = '0; rst_por = 0;
        rst_bor = 0; rst_ext = 0; wdt_wake = 0;
    endtask

    // one cycle: inputs are already set after the negedge; check, model, advance
    task automatic cycle();
        #1;
        check_all();
        model_step();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; quiet();
        irq_en = 8'hFF; irq_prio = '0; cpu_prio = 3'd3; wdt_en = 0;
        clk_sw_en = 1; cur_osc = 3'd5; dflt_osc = 3'd2; fscm_cfg = 1; bor_cfg = 1;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 mode", pwr_mode, 0);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 clk_src", clk_src, 0);
        model_step();
        rst = 0;
        cycle(); cycle();              // R9: src loads 5
        chk("R9 src load", clk_src, 5);
        // R2 sleep entry, then equal priority must not wake (R7)
        cmd_valid = 1; cmd_sleep = 1; cycle(); quiet();
        chk("R2 sleep", pwr_mode, 2);
        cur_osc = 3'd6;
        irq_prio[3*4 +: 3] = 3'd3; irq_req[4] = 1;
        cycle(); cycle();
        chk("R7 equal prio no wake", pwr_mode, 2);
        cmd_valid = 1; cmd_sleep = 0; irq_req = '0; cycle(); quiet();
        chk("R10 cmd ignored", pwr_mode, 2);
        irq_en[4] = 0; irq_prio[3*4 +: 3] = 3'd7; irq_req[4] = 1; cycle(); quiet();
        chk("R7 disabled no wake", pwr_mode, 2);
        irq_en[4] = 1; irq_req[4] = 1; cycle(); quiet();
        chk("R7 higher prio wakes", pwr_mode, 0);
        chk("R9 restored src", clk_src, 5);
        cycle();
        chk("R9 live src after wake", clk_src, 6);
        // R3 idle, R8 watchdog wake
        cmd_valid = 1; cmd_sleep = 0; cycle(); quiet();
        chk("R3 idle", pwr_mode, 1);
        chk("R3 per on", per_clk_en, 1);
        wdt_wake = 1; cycle(); quiet();
        chk("R8 wdt wake", pwr_mode, 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            cmd_valid = ($urandom % 5) == 0;
            cmd_sleep = $urandom % 2;
            for (int i = 0; i < 8; i++) irq_req[i] = ($urandom % 12) == 0;
            irq_en    = $urandom;
            irq_prio  = $urandom;
            cpu_prio  = $urandom;
            rst_por   = ($urandom % 50) == 0;
            rst_bor   = ($urandom % 50) == 0;
            rst_ext   = ($urandom % 50) == 0;
            wdt_wake  = ($urandom % 30) == 0;
            wdt_en    = $urandom % 2;
            clk_sw_en = $urandom % 2;
            cur_osc   = $urandom;
            dflt_osc  = $urandom;
            fscm_cfg  = $urandom % 2;
            bor_cfg   = $urandom % 2;
            rst       = ($urandom % 400) == 0;
            cycle();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule